// File: doc/BRIEF.md
# I2C Target with Instruction-Sequenced Register Access

This block is an I2C target that oversamples SCL and SDA with a fast system clock. It detects START and STOP conditions and matches a fixed device byte. It then takes an instruction byte that selects one of sixteen fixed transfer sequences over an eight-entry register file held inside the block. Each sequence has a set length and a set address order. A sequence can write bytes, read bytes, or write a pair of control bytes and then read data bytes, all within one bus transaction.

The SDA pin is open-drain. The block only pulls the line low or lets it go, and it changes its drive only while SCL is low. The bus has no parallel data stream, so there is no valid/ready pair at the edge. The pins are plain. The register file resets to zero and can be reached only through the bus.

Register map: DR0 at 0, DR1 at 1, DR2 at 2, spare locations at 3 to 5, CAR at 6 and ACR at 7.

Top module: `i2c_instr_target`

## Requirements
- R1: `sda_oe` = 1 pulls SDA low and `sda_oe` = 0 releases the line. `sda_oe` changes only while SCL is low, as seen by the block.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. A STOP returns the block to idle with SDA released and loses any byte that was not complete.
- R3: The first byte after START is accepted if it equals DEV_ID (0x20) with any value in bit 0, so 0x20 and 0x21 are both taken. The block ACKs it by holding SDA low through the ninth clock. Any other value gets no ACK, and the block ignores all bus activity until the next START.
- R4: The block ACKs the instruction byte and decodes it as: bit 7 = direction class (1 = read class), bits 5:3 = sequence select S, bits 2:0 = single-byte address A. Bit 6 has no effect.
- R5: Write-class sequences are:
  - S=0: A
  - S=1: ACR, CAR
  - S=2: CAR, DR0
  - S=3: ACR, CAR, DR0
  - S=4: ACR, CAR, DR1, DR0
  - S=5: ACR, CAR, DR2, DR1, DR0
  - S=7: DR2, DR1, DR0
  
  Each data byte is ACKed and stored once its eighth bit has been received.
- R6: Read-class bytes are shifted out MSB first from the addressed register. A master ACK continues the sequence. A master NACK ends it, and the block then leaves SDA released for every later clock until STOP or START.
- R7: Read-class sequences with a leading write are:
  - S=1: write ACR, CAR
  - S=2: write CAR, then read DR0
  - S=3: write ACR, CAR, then read DR0
  - S=4: write ACR, CAR, then read DR0, DR1
  - S=5: write ACR, CAR, then read DR0, DR1, DR2
  
  Other read-class sequences are S=0 (read A) and S=7 (read DR0, DR1, DR2).
- R8: S=6 covers all eight locations. A write walks addresses 7 down to 0. A read walks addresses 0 up to 7.
- R9: A byte sent after the selected sequence is complete gets no ACK and changes no register.
- R10: A repeated START at any point abandons the current sequence and returns the block to device-byte matching.
- R11: After reset, every register reads 0 and SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume a well-formed bus. SCL stays in each phase for several system clocks, so the synchronized copies see every edge. The master changes SDA only while SCL is low, except when it is making a START or STOP. The master never issues a START or STOP while the target holds SDA low. The bench master is built to keep these rules: each quarter bit lasts ten system clocks, SDA is set in the middle of the low phase, and the master ends every read with a NACK before it sends STOP or a repeated START.

// File: rtl/i2c_ir_pkg.sv
package i2c_ir_pkg;

  localparam int unsigned REG_AW = 3;
  localparam int unsigned REG_DW = 8;

  localparam logic [REG_AW-1:0] LOC_DR0 = 3'd0;
  localparam logic [REG_AW-1:0] LOC_DR1 = 3'd1;
  localparam logic [REG_AW-1:0] LOC_DR2 = 3'd2;
  localparam logic [REG_AW-1:0] LOC_CAR = 3'd6;
  localparam logic [REG_AW-1:0] LOC_ACR = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_DATA,
    ST_SKIP
  } xfer_state_e;

  typedef struct packed {
    logic              valid;
    logic              rd;
    logic [REG_AW-1:0] addr;
  } step_t;

  function automatic step_t mk_step(input logic rd, input logic [REG_AW-1:0] addr);
    step_t s;
    s.valid = 1'b1;
    s.rd    = rd;
    s.addr  = addr;
    return s;
  endfunction

  // Control pair prefix used by several sequences: ACR first, then CAR.
  function automatic logic [REG_AW-1:0] pair_loc(input logic [2:0] lo);
    return (lo == 3'd0) ? LOC_ACR : LOC_CAR;
  endfunction

  // Returns the step at position idx of the sequence picked by {rw, sel}.
  function automatic step_t seq_lookup(input logic rw, input logic [2:0] sel,
                                       input logic [REG_AW-1:0] a, input logic [3:0] idx);
    step_t    s;
    logic [2:0] lo;
    lo = idx[2:0];
    s  = '0;
    if (idx < 4'd8) begin
      case ({rw, sel})
        4'b0000: if (idx == 4'd0) s = mk_step(1'b0, a);
        4'b0001: if (idx < 4'd2) s = mk_step(1'b0, pair_loc(lo));
        4'b0010: if (idx < 4'd2) s = mk_step(1'b0, (lo == 3'd0) ? LOC_CAR : LOC_DR0);
        4'b0011: if (idx < 4'd3) s = mk_step(1'b0, (lo < 3'd2) ? pair_loc(lo) : LOC_DR0);
        4'b0100: if (idx < 4'd4) s = mk_step(1'b0, (lo < 3'd2) ? pair_loc(lo) : 3'd3 - lo);
        4'b0101: if (idx < 4'd5) s = mk_step(1'b0, (lo < 3'd2) ? pair_loc(lo) : 3'd4 - lo);
        4'b0110: s = mk_step(1'b0, 3'd7 - lo);
        4'b0111: if (idx < 4'd3) s = mk_step(1'b0, 3'd2 - lo);
        4'b1000: if (idx == 4'd0) s = mk_step(1'b1, a);
        4'b1001: if (idx < 4'd2) s = mk_step(1'b0, pair_loc(lo));
        4'b1010: if (idx < 4'd2) s = (lo == 3'd0) ? mk_step(1'b0, LOC_CAR) : mk_step(1'b1, LOC_DR0);
        4'b1011: if (idx < 4'd3) s = (lo < 3'd2) ? mk_step(1'b0, pair_loc(lo)) : mk_step(1'b1, LOC_DR0);
        4'b1100: if (idx < 4'd4) s = (lo < 3'd2) ? mk_step(1'b0, pair_loc(lo)) : mk_step(1'b1, lo - 3'd2);
        4'b1101: if (idx < 4'd5) s = (lo < 3'd2) ? mk_step(1'b0, pair_loc(lo)) : mk_step(1'b1, lo - 3'd2);
        4'b1110: s = mk_step(1'b1, lo);
        default: if (idx < 4'd3) s = mk_step(1'b1, lo);
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_ff[g] <= 1'b1;
        sda_ff[g] <= 1'b1;
      end else if (g == 0) begin
        scl_ff[g] <= scl_i;
        sda_ff[g] <= sda_i;
      end else begin
        scl_ff[g] <= scl_ff[(g == 0) ? 0 : g-1];
        sda_ff[g] <= sda_ff[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = ~scl_q & scl_s;
  assign scl_fall  = scl_q & ~scl_s;
  assign start_det = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;

endmodule

// File: rtl/ir_regfile.sv
module ir_regfile #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= '0;
      else if (wr_en && (wr_addr == AW'(i))) mem[i] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_instr_target.sv
module i2c_instr_target
  import i2c_ir_pkg::*;
#(
  parameter logic [7:0]  DEV_ID      = 8'h20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam logic [3:0] BIT_LAST = 4'd7;
  localparam logic [3:0] ACK_CLK  = 4'd8;
  localparam logic [3:0] ACK_END  = 4'd9;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  xfer_state_e       state;
  logic [3:0]        cnt;
  logic [3:0]        step;
  logic [7:0]        sh;
  logic              drive;
  logic              byte_rd;
  logic              nack;
  logic              wr_en;
  logic [REG_AW-1:0] cur_addr;
  logic              ins_rw;
  logic [2:0]        ins_sel;
  logic [REG_AW-1:0] ins_a;
  logic [7:0]        rx_byte;
  logic [3:0]        nxt_idx;
  step_t             entry;
  logic [REG_DW-1:0] rd_data;
  logic              active;

  assign rx_byte = {sh[6:0], sda_s};
  assign active  = (state == ST_ADDR) || (state == ST_INSTR) || (state == ST_DATA);
  assign nxt_idx = (state == ST_DATA) ? step + 4'd1 : 4'd0;
  assign entry   = seq_lookup(ins_rw, ins_sel, ins_a, nxt_idx);

  ir_regfile #(.AW(REG_AW), .DW(REG_DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(cur_addr), .wr_data(sh),
    .rd_addr(entry.addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      step     <= '0;
      sh       <= '0;
      drive    <= 1'b0;
      byte_rd  <= 1'b0;
      nack     <= 1'b0;
      wr_en    <= 1'b0;
      cur_addr <= '0;
      ins_rw   <= 1'b0;
      ins_sel  <= '0;
      ins_a    <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        cnt     <= '0;
        step    <= '0;
        drive   <= 1'b0;
        byte_rd <= 1'b0;
        nack    <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        cnt   <= '0;
        drive <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (cnt < ACK_CLK) begin
            cnt <= cnt + 4'd1;
            if (!byte_rd) begin
              sh <= rx_byte;
              if (cnt == BIT_LAST) begin
                case (state)
                  ST_ADDR:  if (rx_byte[7:1] != DEV_ID[7:1]) state <= ST_IDLE;
                  ST_INSTR: begin
                    ins_rw  <= rx_byte[7];
                    ins_sel <= rx_byte[5:3];
                    ins_a   <= rx_byte[2:0];
                  end
                  default:  wr_en <= 1'b1;
                endcase
              end
            end
          end else if (cnt == ACK_CLK) begin
            cnt  <= ACK_END;
            nack <= byte_rd & sda_s;
          end
        end else if (scl_fall) begin
          if (byte_rd && (cnt >= 4'd1) && (cnt <= BIT_LAST)) begin
            drive <= ~sh[6];
            sh    <= {sh[6:0], 1'b0};
          end else if (cnt == ACK_CLK) begin
            drive <= ~byte_rd;
          end else if (cnt == ACK_END) begin
            cnt   <= '0;
            drive <= 1'b0;
            nack  <= 1'b0;
            if (state == ST_ADDR) begin
              state   <= ST_INSTR;
              byte_rd <= 1'b0;
            end else if (((state == ST_DATA) && nack) || !entry.valid) begin
              state <= ST_SKIP;
            end else begin
              state    <= ST_DATA;
              step     <= nxt_idx;
              byte_rd  <= entry.rd;
              cur_addr <= entry.addr;
              if (entry.rd) begin
                sh    <= rd_data;
                drive <= ~rd_data[7];
              end
            end
          end
        end
      end
    end
  end

  assign sda_oe = drive;

endmodule

// File: rtl/i2c_instr_target_chk.sv
module i2c_instr_target_chk
  import i2c_ir_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        scl_rise,
  input logic        start_det,
  input logic        stop_det,
  input logic        sda_oe,
  input xfer_state_e state,
  input logic [3:0]  cnt,
  input logic [3:0]  step,
  input logic        byte_rd,
  input logic        wr_en
);

  // R1: drive changes only after a cycle with SCL low
  p_oe_scl_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_s));

  // R2: STOP leaves the block idle and released
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> (state == ST_IDLE) && !sda_oe);

  // R3: nothing is driven while idle
  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R5: received bytes are acknowledged through the ninth clock
  p_ack_ninth_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise && (cnt == 4'd8) && !byte_rd &&
    ((state == ST_ADDR) || (state == ST_INSTR) || (state == ST_DATA)) |-> sda_oe);

  // R5: a register write follows a sampled SCL rising edge
  p_wr_after_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(scl_rise) && !byte_rd);

  // R9: the step index never passes the longest sequence
  p_step_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 4'd7);

  // R10: any START rearms device-byte matching
  p_start_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR) && (cnt == 4'd0) && !sda_oe);

endmodule

bind i2c_instr_target i2c_instr_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_rise(scl_rise),
  .start_det(start_det), .stop_det(stop_det), .sda_oe(sda_oe), .state(state),
  .cnt(cnt), .step(step), .byte_rd(byte_rd), .wr_en(wr_en)
);

// File: tb/sim_i2c_instr_target.sv
module sim_i2c_instr_target;

  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  wire  sda_bus = m_sda & ~sda_oe;

  always #4 clk = ~clk;

  i2c_instr_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mdl [8];

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic put(input logic [7:0] b, input bit exp_ack, input string tag);
    bit ack;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    ack = !sda_bus;
    tick(Q);
    m_scl = 1'b0; tick(Q);
    chk8({tag, " ack"}, 8'(ack), 8'(exp_ack));
  endtask

  task automatic get(input bit m_ack, input logic [7:0] exp, input string tag);
    logic [7:0] b;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      m_scl = 1'b1; tick(Q);
      b[i] = sda_bus;
      tick(Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = !m_ack; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
    m_sda = 1'b1;
    chk8(tag, b, exp);
  endtask

  task automatic rd_one(input logic [2:0] a, input string tag);
    bus_start();
    put(8'h21, 1'b1, tag);
    put({5'b10000, a}, 1'b1, tag);
    get(1'b0, mdl[a], tag);
    bus_stop();
  endtask

  task automatic t_reset();
    chk8("R11 sda_oe after reset", 8'(sda_oe), 8'h00);
    bus_start();
    put(8'h21, 1'b1, "R11 addr");
    put(8'hB0, 1'b1, "R11 instr");
    for (int i = 0; i < 8; i++) get(i != 7, 8'h00, "R11 R8 reset value");
    bus_stop();
  endtask

  task automatic t_single();
    bus_start();
    put(8'h20, 1'b1, "R3 addr 0x20");
    put(8'h05, 1'b1, "R4 instr");
    put(8'hA5, 1'b1, "R5 single data");
    bus_stop();
    mdl[5] = 8'hA5;
    rd_one(3'd5, "R6 single read");
    bus_start();
    put(8'h20, 1'b1, "R4 addr");
    put(8'h44, 1'b1, "R4 bit6 set instr");
    put(8'h3C, 1'b1, "R4 bit6 data");
    bus_stop();
    mdl[4] = 8'h3C;
    bus_start();
    put(8'h21, 1'b1, "R4 addr");
    put(8'hC4, 1'b1, "R4 bit6 read instr");
    get(1'b0, mdl[4], "R4 bit6 ignored");
    bus_stop();
  endtask

  task automatic t_all8();
    bus_start();
    put(8'h20, 1'b1, "R8 addr");
    put(8'h30, 1'b1, "R8 instr");
    for (int i = 0; i < 8; i++) begin
      put(8'h10 + 8'(i), 1'b1, "R8 write byte");
      mdl[7-i] = 8'h10 + 8'(i);
    end
    put(8'hEE, 1'b0, "R9 extra write byte");
    bus_stop();
    bus_start();
    put(8'h21, 1'b1, "R8 addr");
    put(8'hB0, 1'b1, "R8 instr");
    for (int i = 0; i < 8; i++) get(i != 7, mdl[i], "R8 read ascending");
    bus_stop();
  endtask

  task automatic t_write_seqs();
    bus_start();
    put(8'h20, 1'b1, "R5 addr");
    put(8'h28, 1'b1, "R5 S5 instr");
    put(8'h71, 1'b1, "R5 ACR"); mdl[7] = 8'h71;
    put(8'h62, 1'b1, "R5 CAR"); mdl[6] = 8'h62;
    put(8'h52, 1'b1, "R5 DR2"); mdl[2] = 8'h52;
    put(8'h51, 1'b1, "R5 DR1"); mdl[1] = 8'h51;
    put(8'h50, 1'b1, "R5 DR0"); mdl[0] = 8'h50;
    put(8'h99, 1'b0, "R9 after S5");
    bus_stop();
    bus_start();
    put(8'h21, 1'b1, "R7 addr");
    put(8'hB8, 1'b1, "R7 S7 instr");
    get(1'b1, mdl[0], "R7 S7 DR0");
    get(1'b1, mdl[1], "R7 S7 DR1");
    get(1'b0, mdl[2], "R7 S7 DR2");
    bus_stop();
    rd_one(3'd7, "R5 ACR check");
    rd_one(3'd6, "R5 CAR check");
    rd_one(3'd4, "R9 spare untouched");
    bus_start();
    put(8'h20, 1'b1, "R5 addr");
    put(8'h38, 1'b1, "R5 S7 instr");
    put(8'hC2, 1'b1, "R5 DR2"); mdl[2] = 8'hC2;
    put(8'hC1, 1'b1, "R5 DR1"); mdl[1] = 8'hC1;
    put(8'hC0, 1'b1, "R5 DR0"); mdl[0] = 8'hC0;
    bus_stop();
    bus_start();
    put(8'h20, 1'b1, "R5 addr");
    put(8'h10, 1'b1, "R5 S2 instr");
    put(8'h66, 1'b1, "R5 S2 CAR"); mdl[6] = 8'h66;
    put(8'hD0, 1'b1, "R5 S2 DR0"); mdl[0] = 8'hD0;
    bus_stop();
    rd_one(3'd6, "R5 S2 CAR check");
  endtask

  task automatic t_mixed();
    bus_start();
    put(8'h21, 1'b1, "R7 addr");
    put(8'hA8, 1'b1, "R7 S5 instr");
    put(8'h77, 1'b1, "R7 ACR"); mdl[7] = 8'h77;
    put(8'h67, 1'b1, "R7 CAR"); mdl[6] = 8'h67;
    get(1'b1, mdl[0], "R7 S5 DR0");
    get(1'b1, mdl[1], "R7 S5 DR1");
    get(1'b0, mdl[2], "R7 S5 DR2");
    bus_stop();
    rd_one(3'd7, "R7 ACR check");
    rd_one(3'd6, "R7 CAR check");
    bus_start();
    put(8'h21, 1'b1, "R7 addr");
    put(8'h88, 1'b1, "R7 S1 instr");
    put(8'h01, 1'b1, "R7 S1 ACR"); mdl[7] = 8'h01;
    put(8'h02, 1'b1, "R7 S1 CAR"); mdl[6] = 8'h02;
    put(8'h03, 1'b0, "R9 after S1");
    bus_stop();
    rd_one(3'd7, "R7 S1 ACR check");
    bus_start();
    put(8'h21, 1'b1, "R7 addr");
    put(8'h90, 1'b1, "R7 S2 instr");
    put(8'h5A, 1'b1, "R7 S2 CAR"); mdl[6] = 8'h5A;
    get(1'b0, mdl[0], "R7 S2 DR0");
    bus_stop();
    rd_one(3'd6, "R7 S2 CAR check");
  endtask

  task automatic t_nack();
    bus_start();
    put(8'h21, 1'b1, "R6 addr");
    put(8'hB0, 1'b1, "R6 instr");
    get(1'b1, mdl[0], "R6 first");
    get(1'b0, mdl[1], "R6 nacked");
    get(1'b0, 8'hFF, "R6 released after NACK");
    bus_stop();
  endtask

  task automatic t_bad_addr();
    bus_start();
    put(8'h22, 1'b0, "R3 wrong id");
    put(8'h07, 1'b0, "R3 ignored instr");
    put(8'hEE, 1'b0, "R3 ignored data");
    bus_stop();
    rd_one(3'd7, "R3 no write");
  endtask

  task automatic t_rstart();
    bus_start();
    put(8'h20, 1'b1, "R10 addr");
    put(8'h03, 1'b1, "R10 instr");
    bus_start();
    put(8'h21, 1'b1, "R10 addr after rstart");
    put(8'h83, 1'b1, "R10 instr after rstart");
    get(1'b0, mdl[3], "R10 value kept");
    bus_stop();
    chk8("R2 released after STOP", 8'(sda_oe), 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_single();
    t_all8();
    t_write_seqs();
    t_mixed();
    t_nack();
    t_bad_addr();
    t_rstart();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule